// File: doc/BRIEF.md
# Wiper Position Register Bank

This block is the digital heart of a 64-position digitally controlled potentiometer. A 6-bit live wiper register selects one of 64 taps on an external resistor ladder. The ladder itself, the serial host link and real nonvolatile cell timing are outside the block. Next to the wiper sit four stored presets. The presets survive a soft reset and are cleared only by a power-on reset.

A host drives a parallel command port with a 3-bit opcode, a 2-bit preset index and a 6-bit value. The host can read or write the wiper, read or write any preset, and copy a preset into the wiper or the wiper into a preset. Each accepted command is answered by a one-cycle done strobe on the following clock edge. Read data is valid in that same cycle. After any reset the wiper is reloaded from preset 0 before commands are accepted. A write-protect input guards the presets. The wiper is decoded into 64 one-hot switch enables.

Top module: `wiper_bank`

## Requirements
- R1: `tap_en` always has exactly one bit set, and that bit is at the index equal to `wiper_pos`.
- R2: While `por` is high at a clock edge, all four presets and the wiper become 0, and `done` and `wp_err` stay low.
- R3: The first clock edge after `por` or `srst` is released is a load cycle. At that edge the wiper takes the value of preset 0, and a command presented there is ignored, with no `done` strobe.
- R4: `srst` leaves the preset contents unchanged. Afterwards the wiper holds preset 0's value.
- R5: Opcode 1 (write wiper) loads `cmd_data` into the wiper at the accepting edge.
- R6: Opcode 3 (write preset) loads `cmd_data` into the preset selected by `cmd_idx`.
- R7: Every accepted command raises `done` for one cycle, registered at the accepting edge. Opcode 0 returns the wiper value and opcode 2 returns preset `cmd_idx`, each zero-extended to 8 bits in `rd_data` during that cycle. All other opcodes return 0.
- R8: Opcode 4 copies preset `cmd_idx` into the wiper. Opcode 5 copies the wiper into preset `cmd_idx`.
- R9: While `wp` is high, opcodes 3 and 5 change nothing and raise `wp_err` together with `done`. Opcodes 1 and 4 still take effect. `wp_err` is low for every other command.
- R10: Opcodes 6 and 7 raise `done` with `rd_data` 0, and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high; clears presets |
| srst | input | 1 | Soft reset, synchronous, active high; keeps presets |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Opcode 0..7 |
| cmd_idx | input | 2 | Preset index |
| cmd_data | input | 6 | Write value |
| wp | input | 1 | Write protect for presets |
| done | output | 1 | Command completed strobe |
| rd_data | output | 8 | Read result, zero-extended |
| wp_err | output | 1 | Protected command refused |
| wiper_pos | output | 6 | Current wiper register |
| tap_en | output | 64 | One-hot tap switch enables |

## Verification
The assertions assume that `por` and `srst` are synchronous, and that nothing in the command fields matters while `cmd_valid` is low. They also assume `wp` is sampled at the same edge as the command it guards. The bench drives every input on the falling edge, so each value is stable across the rising edge. The random stimulus covers all eight opcodes, every index and the full 6-bit data range, with `wp` set about a third of the time. Soft resets are inserted at random, with a command held during the load cycle to show that it is dropped. Power-on reset is applied only in directed sections, after the presets have been loaded with non-zero values.

// File: rtl/wb_pkg.sv
package wb_pkg;
    localparam int POS_W  = 6;
    localparam int NUM_DR = 4;
    localparam int IDX_W  = $clog2(NUM_DR);
    localparam int RD_W   = 8;
    localparam int TAPS   = 1 << POS_W;

    typedef enum logic [2:0] {
        OP_RD_WIPER  = 3'd0,
        OP_WR_WIPER  = 3'd1,
        OP_RD_PRESET = 3'd2,
        OP_WR_PRESET = 3'd3,
        OP_PRE2WIPER = 3'd4,
        OP_WIPER2PRE = 3'd5,
        OP_RSVD6     = 3'd6,
        OP_RSVD7     = 3'd7
    } wb_op_e;

    typedef enum logic [1:0] {
        RD_NONE   = 2'd0,
        RD_WIPER  = 2'd1,
        RD_PRESET = 2'd2
    } wb_rdsel_e;

    typedef struct packed {
        logic      wiper_we;
        logic      wiper_from_pre;
        logic      pre_we;
        logic      pre_from_wiper;
        wb_rdsel_e rd_sel;
        logic      err;
    } wb_ctl_t;

    function automatic logic is_guarded(input wb_op_e op);
        return (op == OP_WR_PRESET) || (op == OP_WIPER2PRE);
    endfunction
endpackage

// File: rtl/wb_cmd_decode.sv
module wb_cmd_decode
    import wb_pkg::*;
(
    input  logic [2:0] op,
    input  logic       wp,
    input  logic       accept,
    output wb_ctl_t    ctl
);
    wb_op_e op_e;
    logic   blocked;

    always_comb begin
        op_e    = wb_op_e'(op);
        blocked = wp && is_guarded(op_e);
        ctl     = '0;
        if (accept) begin
            case (op_e)
                OP_RD_WIPER:  ctl.rd_sel = RD_WIPER;
                OP_RD_PRESET: ctl.rd_sel = RD_PRESET;
                OP_WR_WIPER:  ctl.wiper_we = 1'b1;
                OP_PRE2WIPER: begin
                    ctl.wiper_we       = 1'b1;
                    ctl.wiper_from_pre = 1'b1;
                end
                OP_WR_PRESET: ctl.pre_we = !blocked;
                OP_WIPER2PRE: begin
                    ctl.pre_we         = !blocked;
                    ctl.pre_from_wiper = 1'b1;
                end
                default: ctl = '0;
            endcase
            ctl.err = blocked;
        end
    end
endmodule

// File: rtl/wb_regfile.sv
module wb_regfile
    import wb_pkg::*;
(
    input  logic             clk,
    input  logic             por,
    input  logic             srst,
    input  logic             cmd_valid,
    input  logic             wp,
    input  logic [IDX_W-1:0] idx,
    input  logic [POS_W-1:0] data,
    input  wb_ctl_t          ctl,
    output logic             accept,
    output logic [POS_W-1:0] wiper_q,
    output logic             done_q,
    output logic [RD_W-1:0]  rd_q,
    output logic             err_q
);
    logic [POS_W-1:0]        pre_q [NUM_DR];
    logic                    loading_q;
    logic [NUM_DR*POS_W-1:0] pre_cat;
    logic [POS_W-1:0]        rd_val;

    assign accept = cmd_valid && !loading_q;

    always_comb begin
        for (int i = 0; i < NUM_DR; i++) pre_cat[i*POS_W +: POS_W] = pre_q[i];
        case (ctl.rd_sel)
            RD_WIPER:  rd_val = wiper_q;
            RD_PRESET: rd_val = pre_q[idx];
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (por) begin
            for (int i = 0; i < NUM_DR; i++) pre_q[i] <= '0;
            wiper_q   <= '0;
            loading_q <= 1'b1;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
            rd_q      <= '0;
        end else if (srst) begin
            loading_q <= 1'b1;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
            rd_q      <= '0;
        end else if (loading_q) begin
            wiper_q   <= pre_q[0];
            loading_q <= 1'b0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
            rd_q      <= '0;
        end else begin
            done_q <= accept;
            err_q  <= ctl.err;
            rd_q   <= RD_W'(rd_val);
            if (ctl.wiper_we)
                wiper_q <= ctl.wiper_from_pre ? pre_q[idx] : data;
            if (ctl.pre_we)
                pre_q[idx] <= ctl.pre_from_wiper ? wiper_q : data;
        end
    end

    AST_LOAD_FROM_PRESET0: assert property (@(posedge clk) disable iff (por || srst)
        loading_q |=> wiper_q == $past(pre_q[0])); // R3
    AST_SRST_KEEPS_PRESETS: assert property (@(posedge clk) disable iff (por)
        srst |=> $stable(pre_cat)); // R4
    AST_WP_KEEPS_PRESETS: assert property (@(posedge clk) disable iff (por)
        wp |=> $stable(pre_cat)); // R9
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (por || srst)
        err_q |-> done_q); // R9
    AST_NO_DONE_AFTER_LOAD: assert property (@(posedge clk) disable iff (por || srst)
        loading_q |=> !done_q); // R3
endmodule

// File: rtl/wb_tap_decode.sv
module wb_tap_decode
    import wb_pkg::*;
(
    input  logic             clk,
    input  logic             por,
    input  logic [POS_W-1:0] wiper,
    output logic [TAPS-1:0]  tap_en
);
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        assign tap_en[t] = (wiper == POS_W'(t));
    end

    AST_TAP_ONE_HOT: assert property (@(posedge clk) disable iff (por)
        $countones(tap_en) == 1); // R1
    AST_TAP_MATCHES: assert property (@(posedge clk) disable iff (por)
        tap_en[wiper]); // R1
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
    import wb_pkg::*;
(
    input  logic             clk,
    input  logic             por,
    input  logic             srst,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [IDX_W-1:0] cmd_idx,
    input  logic [POS_W-1:0] cmd_data,
    input  logic             wp,
    output logic             done,
    output logic [RD_W-1:0]  rd_data,
    output logic             wp_err,
    output logic [POS_W-1:0] wiper_pos,
    output logic [TAPS-1:0]  tap_en
);
    wb_ctl_t ctl;
    logic    accept;

    wb_cmd_decode u_dec (
        .op     (cmd_op),
        .wp     (wp),
        .accept (accept),
        .ctl    (ctl)
    );

    wb_regfile u_regs (
        .clk       (clk),
        .por       (por),
        .srst      (srst),
        .cmd_valid (cmd_valid),
        .wp        (wp),
        .idx       (cmd_idx),
        .data      (cmd_data),
        .ctl       (ctl),
        .accept    (accept),
        .wiper_q   (wiper_pos),
        .done_q    (done),
        .rd_q      (rd_data),
        .err_q     (wp_err)
    );

    wb_tap_decode u_tap (
        .clk    (clk),
        .por    (por),
        .wiper  (wiper_pos),
        .tap_en (tap_en)
    );

    AST_DONE_NEEDS_CMD: assert property (@(posedge clk) disable iff (por || srst)
        done |-> $past(cmd_valid)); // R7
endmodule

// File: tb/wiper_bank_bench.sv
module wiper_bank_bench;
    logic clk = 1'b0;
    logic por, srst, cmd_valid, wp;
    logic [2:0] cmd_op;
    logic [1:0] cmd_idx;
    logic [5:0] cmd_data;
    logic done, wp_err;
    logic [7:0] rd_data;
    logic [5:0] wiper_pos;
    logic [63:0] tap_en;

    int n_chk = 0;
    int n_bad = 0;
    logic [5:0] m_pre [4];
    logic [5:0] m_wiper;

    always #5 clk = ~clk;

    wiper_bank u_wiper_bank (
        .clk(clk), .por(por), .srst(srst), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_data(cmd_data), .wp(wp),
        .done(done), .rd_data(rd_data), .wp_err(wp_err),
        .wiper_pos(wiper_pos), .tap_en(tap_en)
    );

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [2:0] op, input logic [1:0] idx);
        if (op == 3'd0) return {2'b00, m_wiper};
        if (op == 3'd2) return {2'b00, m_pre[idx]};
        return 8'd0;
    endfunction

    function automatic bit exp_err(input logic [2:0] op, input bit w);
        return w && (op == 3'd3 || op == 3'd5);
    endfunction

    task automatic check_taps(input string rq);
        chk(tap_en == (64'd1 << m_wiper), rq, tap_en, 64'd1 << m_wiper);
    endtask

    task automatic issue(input logic [2:0] op, input logic [1:0] idx, input logic [5:0] d, input bit w);
        logic [7:0] e_rd;
        bit e_err;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx; cmd_data = d; wp = w;
        e_rd  = exp_rd(op, idx);
        e_err = exp_err(op, w);
        case (op)
            3'd1: m_wiper = d;
            3'd3: if (!w) m_pre[idx] = d;
            3'd4: m_wiper = m_pre[idx];
            3'd5: if (!w) m_pre[idx] = m_wiper;
            default: ;
        endcase
        @(posedge clk); #1;
        chk(done == 1'b1, "R7 done", done, 1);
        chk(rd_data == e_rd, "R7 rd_data", rd_data, e_rd);
        chk(wp_err == e_err, "R9 wp_err", wp_err, e_err);
        chk(wiper_pos == m_wiper, "R5/R8 wiper", wiper_pos, m_wiper);
        check_taps("R1 taps");
    endtask

    task automatic reset_and_load(input bit power);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (power) por = 1'b1; else srst = 1'b1;
        @(negedge clk);
        if (power) begin
            for (int i = 0; i < 4; i++) m_pre[i] = 6'd0;
            m_wiper = 6'd0;
            chk(done == 1'b0 && wp_err == 1'b0, "R2 outputs in por", {done, wp_err}, 0);
            chk(wiper_pos == 6'd0, "R2 wiper in por", wiper_pos, 0);
        end
        por = 1'b0; srst = 1'b0;
        cmd_valid = 1'b1; cmd_op = 3'd1; cmd_data = ~m_pre[0]; wp = 1'b0;
        m_wiper = m_pre[0];
        @(posedge clk); #1;
        chk(done == 1'b0, "R3 load cycle ignores command", done, 0);
        chk(wiper_pos == m_wiper, "R3/R4 wiper from preset0", wiper_pos, m_wiper);
        check_taps("R1 taps after load");
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    initial begin
        #1500000;
        n_bad++;
        $display("FAIL watchdog act=0 exp=1");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        por = 1'b1; srst = 1'b0; cmd_valid = 1'b0; wp = 1'b0;
        cmd_op = 3'd0; cmd_idx = 2'd0; cmd_data = 6'd0;
        for (int i = 0; i < 4; i++) m_pre[i] = 6'd0;
        m_wiper = 6'd0;
        repeat (3) @(negedge clk);
        reset_and_load(1'b1);

        // directed: R5 R6 R8 and extremes
        issue(3'd1, 2'd0, 6'd63, 1'b0);
        issue(3'd0, 2'd0, 6'd0, 1'b0);
        for (int i = 0; i < 4; i++) issue(3'd3, 2'(i), 6'(10 + i * 17), 1'b0);
        for (int i = 0; i < 4; i++) issue(3'd2, 2'(i), 6'd0, 1'b0);
        issue(3'd4, 2'd3, 6'd0, 1'b0);
        issue(3'd1, 2'd0, 6'd0, 1'b0);
        issue(3'd5, 2'd1, 6'd0, 1'b0);
        issue(3'd2, 2'd1, 6'd0, 1'b0);
        // R9 protection
        issue(3'd3, 2'd2, 6'd5, 1'b1);
        issue(3'd5, 2'd0, 6'd0, 1'b1);
        issue(3'd1, 2'd0, 6'd33, 1'b1);
        issue(3'd4, 2'd2, 6'd0, 1'b1);
        issue(3'd2, 2'd2, 6'd0, 1'b0);
        // R10 reserved
        issue(3'd6, 2'd1, 6'd7, 1'b0);
        issue(3'd7, 2'd2, 6'd9, 1'b1);
        issue(3'd0, 2'd0, 6'd0, 1'b0);
        // R4 soft reset keeps presets
        reset_and_load(1'b0);
        for (int i = 0; i < 4; i++) issue(3'd2, 2'(i), 6'd0, 1'b0);

        // random
        void'($urandom(32'd1234));
        for (int n = 0; n < 600; n++) begin
            if ($urandom_range(39) == 0) reset_and_load(1'b0);
            else issue(3'($urandom_range(7)), 2'($urandom_range(3)),
                       6'($urandom_range(63)), $urandom_range(2) == 0);
        end

        // R2 power-on clears presets after non-zero values
        for (int i = 0; i < 4; i++) issue(3'd3, 2'(i), 6'(i + 40), 1'b0);
        reset_and_load(1'b1);
        for (int i = 0; i < 4; i++) issue(3'd2, 2'(i), 6'd0, 1'b0);

        @(negedge clk);
        cmd_valid = 1'b0;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule